// File: doc/BRIEF.md
# On-Off Threshold Backpressure Controller

This block replaces per-flit credit return between two routers with a hysteresis-based stop/go signal. The downstream half tracks how many slots of the receiving flit buffer are free, from the enqueue and dequeue strobes of that buffer. It emits one signal event only when that count crosses a programmable threshold. When free space runs low (below the stop threshold) it sends a stop event. When enough space has drained again (above the resume threshold) it sends a go event. No event is produced for individual flits. The upstream half is a sender gate: it latches the most recent event arriving over the link and enables or disables flit issue.

The two thresholds are inputs. The stop threshold must leave room for every flit already in flight while the stop event travels upstream. The resume threshold must be high enough that the buffer does not drain empty before fresh flits arrive. The resume threshold has to be strictly above the stop threshold. A setting that breaks this rule is flagged, and the controller holds the stop state for as long as the setting persists. The link between the two halves is left to the surrounding design, so any wire or pipeline delay fits between `sig_valid_o`/`sig_on_o` and `link_valid_i`/`link_on_i`.

Top module: `onoff_bp_ctrl`

## Requirements
- R1: After reset the free count equals DEPTH, the state level is go (`state_on_o`=1), `send_en_o`=1 and `sig_valid_o`=0.
- R2: In the cycle after an edge that samples `enq_i` alone, the free count is one lower. With `deq_i` alone it is one higher. With both strobes together it is unchanged.
- R3: The free count never leaves 0..DEPTH. An enqueue alone at count 0 is ignored, and a dequeue alone at count DEPTH is ignored.
- R4: While in go and with a legal setting, a registered free count below `thr_off_i` makes the next cycle show `state_on_o`=0, with `sig_valid_o`=1 and `sig_on_o`=0.
- R5: While in stop and with a legal setting, a free count above `thr_on_i` makes the next cycle show `state_on_o`=1, with `sig_valid_o`=1 and `sig_on_o`=1.
- R6: While the free count lies from `thr_off_i` to `thr_on_i` inclusive and the setting is legal, the state level does not change.
- R7: `sig_valid_o` is high for exactly the one cycle in which `state_on_o` has just changed, and `sig_on_o` then carries the new level. It is low in every other cycle.
- R8: `cfg_bad_o` is high, combinationally, whenever `thr_on_i` <= `thr_off_i`. While it is high, the state goes to stop on the next edge and stays there.
- R9: `send_en_o` takes the value of `link_on_i` one cycle after an edge where `link_valid_i`=1, and holds its value otherwise.
- R10: In a closed loop where the sender enqueues whenever `send_en_o`=1, a stop threshold that covers the round trip keeps every enqueue landing on a free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_i | input | 1 | A flit was written into the downstream buffer |
| deq_i | input | 1 | A flit left the downstream buffer |
| thr_off_i | input | CW | Stop threshold: stop when free < this |
| thr_on_i | input | CW | Resume threshold: go when free > this |
| link_valid_i | input | 1 | Event arriving at the sender side |
| link_on_i | input | 1 | Kind of the arriving event (1 go, 0 stop) |
| sig_valid_o | output | 1 | One-cycle event strobe toward the sender |
| sig_on_o | output | 1 | Kind of the emitted event (1 go, 0 stop) |
| state_on_o | output | 1 | Current go/stop level |
| cfg_bad_o | output | 1 | Threshold pair is illegal |
| free_o | output | CW | Registered free-slot count |
| send_en_o | output | 1 | Sender may issue flits |

## Verification
The properties assume that thresholds change only between clock edges. They also assume that events reach the sender side only as the single-cycle strobes this block emits, delayed by a fixed number of stages. The bench drives every input at the falling edge and builds the link as a shift register of those same outputs. Events therefore reach `link_valid_i` one strobe per cycle and never out of order. Overflow and underflow attempts come only from deliberate directed steps. In the closed-loop run, the stop threshold is chosen larger than the enqueues that can land during one signal round trip.

// File: rtl/onoff_pkg.sv
`timescale 1ns/1ps
package onoff_pkg;

  // Next free-slot count with saturation at both ends.
  function automatic int unsigned free_next(input int unsigned cur,
                                            input int unsigned depth,
                                            input logic enq,
                                            input logic deq);
    if (enq && deq)             return cur;
    else if (enq && cur != 0)   return cur - 1;
    else if (deq && cur < depth) return cur + 1;
    else                        return cur;
  endfunction

  // Threshold pair legality: resume must sit strictly above stop.
  function automatic logic thr_illegal(input int unsigned t_off,
                                       input int unsigned t_on);
    return (t_on <= t_off);
  endfunction

  // Hysteresis decision for the go/stop level.
  function automatic logic level_next(input logic cur_on,
                                      input logic bad,
                                      input int unsigned free,
                                      input int unsigned t_off,
                                      input int unsigned t_on);
    if (bad)                        return 1'b0;
    else if (cur_on && free < t_off) return 1'b0;
    else if (!cur_on && free > t_on) return 1'b1;
    else                            return cur_on;
  endfunction

endpackage

// File: rtl/onoff_free_cnt.sv
`timescale 1ns/1ps
module onoff_free_cnt #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_i,
  input  logic          deq_i,
  output logic [CW-1:0] free_o
);
  localparam logic [CW-1:0] FULL_FREE = CW'(DEPTH);

  logic [CW-1:0] free_q;
  logic [CW-1:0] free_d;

  assign free_d = CW'(onoff_pkg::free_next(int'(unsigned'(free_q)), DEPTH, enq_i, deq_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= FULL_FREE;
    else        free_q <= free_d;
  end

  assign free_o = free_q;
endmodule

// File: rtl/onoff_hyst.sv
`timescale 1ns/1ps
module onoff_hyst #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] free_i,
  input  logic [CW-1:0] thr_off_i,
  input  logic [CW-1:0] thr_on_i,
  output logic          bad_o,
  output logic          lvl_nxt_o,
  output logic          lvl_o,
  output logic          evt_valid_o,
  output logic          evt_on_o
);
  logic lvl_q;
  logic evt_q;

  assign bad_o = onoff_pkg::thr_illegal(int'(unsigned'(thr_off_i)),
                                        int'(unsigned'(thr_on_i)));

  assign lvl_nxt_o = onoff_pkg::level_next(lvl_q, bad_o,
                                           int'(unsigned'(free_i)),
                                           int'(unsigned'(thr_off_i)),
                                           int'(unsigned'(thr_on_i)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      evt_q <= 1'b0;
    end else begin
      lvl_q <= lvl_nxt_o;
      evt_q <= (lvl_nxt_o != lvl_q);
    end
  end

  assign lvl_o       = lvl_q;
  assign evt_valid_o = evt_q;
  assign evt_on_o    = lvl_q;
endmodule

// File: rtl/onoff_tx_gate.sv
`timescale 1ns/1ps
module onoff_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_valid_i,
  input  logic evt_on_i,
  output logic send_en_o
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          en_q <= 1'b1;
    else if (evt_valid_i) en_q <= evt_on_i;
  end

  assign send_en_o = en_q;
endmodule

// File: rtl/onoff_bp_ctrl.sv
`timescale 1ns/1ps
module onoff_bp_ctrl #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_i,
  input  logic          deq_i,
  input  logic [CW-1:0] thr_off_i,
  input  logic [CW-1:0] thr_on_i,
  input  logic          link_valid_i,
  input  logic          link_on_i,
  output logic          sig_valid_o,
  output logic          sig_on_o,
  output logic          state_on_o,
  output logic          cfg_bad_o,
  output logic [CW-1:0] free_o,
  output logic          send_en_o
);
  // Named internal events, brought out for the checker.
  logic [CW-1:0] free_w;
  logic          bad_w;
  logic          lvl_nxt_w;
  logic          lvl_w;
  logic          evt_v_w;
  logic          evt_on_w;
  logic          send_w;

  onoff_free_cnt #(.DEPTH(DEPTH), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enq_i(enq_i), .deq_i(deq_i), .free_o(free_w)
  );

  onoff_hyst #(.CW(CW)) u_hyst (
    .clk(clk), .rst_n(rst_n), .free_i(free_w),
    .thr_off_i(thr_off_i), .thr_on_i(thr_on_i),
    .bad_o(bad_w), .lvl_nxt_o(lvl_nxt_w), .lvl_o(lvl_w),
    .evt_valid_o(evt_v_w), .evt_on_o(evt_on_w)
  );

  onoff_tx_gate u_gate (
    .clk(clk), .rst_n(rst_n),
    .evt_valid_i(link_valid_i), .evt_on_i(link_on_i),
    .send_en_o(send_w)
  );

  assign free_o      = free_w;
  assign cfg_bad_o   = bad_w;
  assign state_on_o  = lvl_w;
  assign sig_valid_o = evt_v_w;
  assign sig_on_o    = evt_on_w;
  assign send_en_o   = send_w;
endmodule

// File: rtl/onoff_bp_chk.sv
`timescale 1ns/1ps
module onoff_bp_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enq,
  input logic          deq,
  input logic [CW-1:0] t_off,
  input logic [CW-1:0] t_on,
  input logic          lnk_v,
  input logic          lnk_on,
  input logic [CW-1:0] free,
  input logic          bad,
  input logic          lvl,
  input logic          evt_v,
  input logic          evt_on,
  input logic          send
);
  localparam logic [CW-1:0] FULL_FREE = CW'(DEPTH);

  a_r2_enq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enq && !deq && free != '0) |=> (free == $past(free) - 1'b1));

  a_r2_deq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (deq && !enq && free != FULL_FREE) |=> (free == $past(free) + 1'b1));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (free <= FULL_FREE));

  a_r3_hold_at_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (enq && !deq && free == '0) |=> (free == '0));

  a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl && !bad && free < t_off) |=> (!lvl && evt_v && !evt_on));

  a_r5_go: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl && !bad && free > t_on) |=> (lvl && evt_v && evt_on));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad && free >= t_off && free <= t_on) |=> $stable(lvl));

  a_r7_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    evt_v |-> (lvl != $past(lvl)));

  a_r7_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_v |-> $stable(lvl));

  a_r8_bad_forces_stop: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> !lvl);

  a_r9_gate_load: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_v |=> (send == $past(lnk_on)));

  a_r9_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lnk_v |=> $stable(send));
endmodule

bind onoff_bp_ctrl onoff_bp_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enq(enq_i), .deq(deq_i),
  .t_off(thr_off_i), .t_on(thr_on_i),
  .lnk_v(link_valid_i), .lnk_on(link_on_i),
  .free(free_w), .bad(bad_w), .lvl(lvl_w),
  .evt_v(evt_v_w), .evt_on(evt_on_w), .send(send_w)
);

// File: tb/onoff_bp_ctrl_tb.sv
`timescale 1ns/1ps
module onoff_bp_ctrl_tb;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_i = 1'b0, deq_i = 1'b0;
  logic [CW-1:0] thr_off_i = CW'(4), thr_on_i = CW'(10);
  logic link_valid_i = 1'b0, link_on_i = 1'b0;
  logic sig_valid_o, sig_on_o, state_on_o, cfg_bad_o, send_en_o;
  logic [CW-1:0] free_o;

  int errors = 0, checks = 0;
  int pulses = 0, ovf = 0, toggles = 0;
  bit pipe_v [LAT];
  bit pipe_on[LAT];

  // Behavioural reference state
  int m_free = DEPTH;
  bit m_on = 1, m_pulse = 0, m_send = 1;

  always #2.5 clk = ~clk;

  onoff_bp_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .enq_i(enq_i), .deq_i(deq_i),
    .thr_off_i(thr_off_i), .thr_on_i(thr_on_i),
    .link_valid_i(link_valid_i), .link_on_i(link_on_i),
    .sig_valid_o(sig_valid_o), .sig_on_o(sig_on_o), .state_on_o(state_on_o),
    .cfg_bad_o(cfg_bad_o), .free_o(free_o), .send_en_o(send_en_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_free = DEPTH; m_on = 1; m_pulse = 0; m_send = 1;
    end else begin
      int  f_old;
      bit  on_new;
      bit  bad;
      f_old = m_free;
      bad = (int'(thr_on_i) <= int'(thr_off_i));
      if (bad) on_new = 0;
      else if (m_on && f_old < int'(thr_off_i)) on_new = 0;
      else if (!m_on && f_old > int'(thr_on_i)) on_new = 1;
      else on_new = m_on;
      m_pulse = (on_new != m_on);
      m_on = on_new;
      if (enq_i && !deq_i && m_free > 0) m_free--;
      else if (deq_i && !enq_i && m_free < DEPTH) m_free++;
      if (link_valid_i) m_send = link_on_i;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit bad_m;
    bad_m = (int'(thr_on_i) <= int'(thr_off_i));
    check("R2 free count", int'(free_o), m_free);
    check("R4/R5 state level", int'(state_on_o), int'(m_on));
    check("R7 event strobe", int'(sig_valid_o), int'(m_pulse));
    if (m_pulse) check("R7 event kind", int'(sig_on_o), int'(m_on));
    check("R8 illegal flag", int'(cfg_bad_o), int'(bad_m));
    check("R9 send enable", int'(send_en_o), int'(m_send));
    if (sig_valid_o) pulses++;
  endtask

  // Called at a falling edge: advance link, apply strobes, run one cycle.
  task automatic step(input logic e, input logic d);
    bit prev_send;
    for (int k = LAT - 1; k > 0; k--) begin
      pipe_v[k]  = pipe_v[k-1];
      pipe_on[k] = pipe_on[k-1];
    end
    pipe_v[0]  = sig_valid_o;
    pipe_on[0] = sig_on_o;
    link_valid_i = pipe_v[LAT-1];
    link_on_i    = pipe_on[LAT-1];
    if (e && !d && m_free == 0) ovf++;
    enq_i = e; deq_i = d;
    prev_send = send_en_o;
    @(negedge clk);
    if (send_en_o != prev_send) toggles++;
    compare_all();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int k = 0; k < LAT; k++) begin pipe_v[k] = 0; pipe_on[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 free after reset", int'(free_o), DEPTH);
    check("R1 level after reset", int'(state_on_o), 1);
    check("R1 send after reset", int'(send_en_o), 1);
    check("R1 no strobe after reset", int'(sig_valid_o), 0);

    // Drain free space: stop=4, resume=10
    pulses = 0;
    repeat (13) step(1, 0);
    check("R2 free after 13 enq", int'(free_o), 3);
    step(0, 0);
    check("R4 stop level", int'(state_on_o), 0);
    check("R4 stop strobe", int'(sig_valid_o), 1);
    repeat (LAT + 1) step(0, 0);
    check("R9 sender stopped", int'(send_en_o), 0);
    repeat (5) step(1, 0);
    check("R3 enq at empty ignored", int'(free_o), 0);
    step(1, 1);
    check("R2 enq+deq unchanged", int'(free_o), 0);
    repeat (10) step(0, 1);
    step(1, 1);
    step(0, 0);
    check("R6 hold at resume threshold", int'(state_on_o), 0);
    check("R2 free at 10", int'(free_o), 10);
    step(0, 1);
    step(0, 0);
    check("R5 go level", int'(state_on_o), 1);
    check("R5 go strobe kind", int'(sig_on_o), 1);
    repeat (LAT + 1) step(0, 0);
    check("R9 sender resumed", int'(send_en_o), 1);
    repeat (8) step(0, 1);
    check("R3 deq at full ignored", int'(free_o), DEPTH);
    check("R7 two strobes for two crossings", pulses, 2);

    // R8 illegal threshold pair
    thr_on_i = CW'(5); thr_off_i = CW'(5);
    step(0, 0);
    check("R8 flag raised", int'(cfg_bad_o), 1);
    check("R8 forced stop", int'(state_on_o), 0);
    repeat (3) step(0, 1);
    check("R8 stop held", int'(state_on_o), 0);
    thr_on_i = CW'(10); thr_off_i = CW'(6);
    step(0, 0);
    check("R8 recovery go", int'(state_on_o), 1);
    repeat (LAT + 2) step(0, 0);

    // R10 closed loop: sender obeys send_en_o, drain every other cycle
    ovf = 0; toggles = 0;
    for (int i = 0; i < 300; i++) step(send_en_o, (i % 2) == 0);
    check("R10 no enqueue at zero free", ovf, 0);
    check("R10 loop throttled", int'(toggles > 2), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule